// File: doc/BRIEF.md
# ECC Beat Error Classifier and Counter

This block sits on the read return path of a memory controller, just after a row of SECDED decoders that each cover one 64-bit lane of a wide read beat. Each decoder reports a single-bit flag (corrected) and a double-bit flag (uncorrectable) for its lane. The block folds those per-lane flags into one class for the whole beat: clean, single-bit or double-bit. A double-bit lane outranks any single-bit lanes in the same beat.

The corrected data is forwarded in the same cycle with no added register stage. A double-bit sideband bit travels with that beat. Two saturating counters record error beats, one for single-bit beats and one for double-bit beats. The block also keeps a record of the most recent error: its beat address, the lane and whether it was double-bit. The counters and the record are read through an APB slave port, and each of them is cleared by writing a one to its own bit in a clear register.

Top module: `ecc_beat_classifier`

## Requirements
- R1: After reset both counters read 0 and the error record register (offset 0x08) reads 0.
- R2: `out_valid` and `out_data` equal `in_valid` and `in_data` in the same cycle, with no register stage between them.
- R3: `out_dbe` is 1 in exactly those cycles where `in_valid` is 1 and at least one bit of `in_dbe` is 1.
- R4: A valid beat with one or more `in_sbe` bits set and no `in_dbe` bit set adds exactly 1 to the single-bit counter (offset 0x00) and leaves the double-bit counter unchanged.
- R5: A valid beat with one or more `in_dbe` bits set adds exactly 1 to the double-bit counter (offset 0x04). The single-bit counter stays unchanged even when `in_sbe` bits are also set.
- R6: When `in_valid` is 0, the lane flags have no effect on the counters or on the record.
- R7: Each counter stops at its all-ones value and never wraps to 0 from further error beats.
- R8: An APB write to offset 0x10 clears the single-bit counter when bit 0 is 1, clears the double-bit counter when bit 1 is 1, and clears the record when bit 2 is 1. A 0 in a bit leaves its target alone. If a clear and an increment fall in the same cycle, the clear wins.
- R9: Every error beat that updates the record stores `in_addr` at offset 0x0C. It also writes offset 0x08 as follows: bit 0 = 1 (record valid), bit 1 = 1 for a double-bit beat and 0 for a single-bit beat, and bits [11:4] = the lowest-numbered lane that carries the beat's class of error.
- R10: A double-bit beat always overwrites the record. A single-bit beat overwrites the record only when the record is empty or holds a single-bit error.
- R11: APB reads of an offset outside 0x00, 0x04, 0x08 and 0x0C return 0, and `pready` is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Read beat valid from the decoders |
| in_data | input | NUM_LANES*LANE_W | Corrected read data from the decoders |
| in_sbe | input | NUM_LANES | Per-lane single-bit (corrected) flag |
| in_dbe | input | NUM_LANES | Per-lane double-bit (uncorrectable) flag |
| in_addr | input | ADDR_W | Address of the read beat |
| out_valid | output | 1 | Forwarded beat valid |
| out_data | output | NUM_LANES*LANE_W | Forwarded corrected data |
| out_dbe | output | 1 | Double-bit sideband for the forwarded beat |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable |
| pwrite | input | 1 | APB write |
| paddr | input | 8 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, always 1 |

## Verification
The hardest situations to reach from the ports involve the record priority. A single-bit beat must arrive while a double-bit record is held, and the bench must then read the record back to confirm it was not overwritten. Counter saturation is similar, because it needs a long run of error beats. The bench builds the counters narrow so that saturation comes within a few dozen beats. It places single-bit beats after a double-bit beat, both before and after a clear of the record. It also sends mixed beats, with single-bit and double-bit flags on different lanes, and flags that are set while `in_valid` is 0.

// File: rtl/ecc_cls_pkg.sv
package ecc_cls_pkg;

    typedef enum logic [1:0] {
        BEAT_CLEAN  = 2'd0,
        BEAT_SINGLE = 2'd1,
        BEAT_DOUBLE = 2'd2
    } beat_cls_e;

    localparam logic [7:0] OFS_SB_CNT = 8'h00;
    localparam logic [7:0] OFS_DB_CNT = 8'h04;
    localparam logic [7:0] OFS_RECORD = 8'h08;
    localparam logic [7:0] OFS_ADDR   = 8'h0C;
    localparam logic [7:0] OFS_CLEAR  = 8'h10;

    localparam int unsigned CLR_SB  = 0;
    localparam int unsigned CLR_DB  = 1;
    localparam int unsigned CLR_REC = 2;
    localparam int unsigned CLR_W   = 3;

endpackage

// File: rtl/ecc_lane_fold.sv
module ecc_lane_fold
    import ecc_cls_pkg::*;
#(
    parameter int unsigned NUM_LANES = 4,
    parameter int unsigned IDX_W     = 2
) (
    input  logic                 valid,
    input  logic [NUM_LANES-1:0] sbe,
    input  logic [NUM_LANES-1:0] dbe,
    output beat_cls_e            cls,
    output logic [IDX_W-1:0]     lane_idx
);

    logic [NUM_LANES-1:0] sbe_m;
    logic [NUM_LANES-1:0] dbe_m;

    genvar g;
    generate
        for (g = 0; g < NUM_LANES; g++) begin : g_mask
            assign sbe_m[g] = valid & sbe[g];
            assign dbe_m[g] = valid & dbe[g];
        end
    endgenerate

    logic [IDX_W-1:0] sb_first;
    logic [IDX_W-1:0] db_first;

    always_comb begin
        sb_first = '0;
        db_first = '0;
        for (int i = NUM_LANES - 1; i >= 0; i--) begin
            if (sbe_m[i]) sb_first = IDX_W'(i);
            if (dbe_m[i]) db_first = IDX_W'(i);
        end
    end

    always_comb begin
        if (|dbe_m) begin
            cls      = BEAT_DOUBLE;
            lane_idx = db_first;
        end else if (|sbe_m) begin
            cls      = BEAT_SINGLE;
            lane_idx = sb_first;
        end else begin
            cls      = BEAT_CLEAN;
            lane_idx = '0;
        end
    end

endmodule

// File: rtl/ecc_sat_counter.sv
module ecc_sat_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.cnt = '0;
        end else if (inc && (st_q.cnt != {CNT_W{1'b1}})) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;

endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log
    import ecc_cls_pkg::*;
#(
    parameter int unsigned IDX_W  = 2,
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  beat_cls_e         cls,
    input  logic [IDX_W-1:0]  lane_idx,
    input  logic [ADDR_W-1:0] addr,
    input  logic              clr,
    output logic              rec_valid,
    output logic              rec_dbl,
    output logic [IDX_W-1:0]  rec_lane,
    output logic [ADDR_W-1:0] rec_addr
);

    typedef struct packed {
        logic              valid;
        logic              dbl;
        logic [IDX_W-1:0]  lane;
        logic [ADDR_W-1:0] addr;
    } rec_state_t;

    rec_state_t st_d, st_q;
    logic       take;

    always_comb begin
        st_d = st_q;
        take = 1'b0;
        if (cls == BEAT_DOUBLE) begin
            take = 1'b1;
        end else if (cls == BEAT_SINGLE) begin
            take = !(st_q.valid && st_q.dbl) || clr;
        end
        if (clr && !take) begin
            st_d = '0;
        end else if (take) begin
            st_d.valid = 1'b1;
            st_d.dbl   = (cls == BEAT_DOUBLE);
            st_d.lane  = lane_idx;
            st_d.addr  = addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rec_valid = st_q.valid;
    assign rec_dbl   = st_q.dbl;
    assign rec_lane  = st_q.lane;
    assign rec_addr  = st_q.addr;

endmodule

// File: rtl/ecc_apb_regs.sv
module ecc_apb_regs
    import ecc_cls_pkg::*;
#(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned IDX_W  = 2,
    parameter int unsigned ADDR_W = 32
) (
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [7:0]        paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    output logic              pready,
    input  logic [CNT_W-1:0]  sb_cnt,
    input  logic [CNT_W-1:0]  db_cnt,
    input  logic              rec_valid,
    input  logic              rec_dbl,
    input  logic [IDX_W-1:0]  rec_lane,
    input  logic [ADDR_W-1:0] rec_addr,
    output logic [CLR_W-1:0]  clr
);

    logic        wr_clear;
    logic [31:0] rec_word;

    assign wr_clear = psel && penable && pwrite && (paddr == OFS_CLEAR);
    assign pready   = 1'b1;

    genvar g;
    generate
        for (g = 0; g < CLR_W; g++) begin : g_clr
            assign clr[g] = wr_clear & pwdata[g];
        end
    endgenerate

    always_comb begin
        rec_word       = '0;
        rec_word[0]    = rec_valid;
        rec_word[1]    = rec_dbl;
        rec_word[11:4] = 8'(rec_lane);
    end

    always_comb begin
        prdata = '0;
        if (psel && !pwrite) begin
            case (paddr)
                OFS_SB_CNT: prdata = 32'(sb_cnt);
                OFS_DB_CNT: prdata = 32'(db_cnt);
                OFS_RECORD: prdata = rec_word;
                OFS_ADDR:   prdata = 32'(rec_addr);
                default:    prdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/ecc_beat_classifier.sv
module ecc_beat_classifier
    import ecc_cls_pkg::*;
#(
    parameter int unsigned NUM_LANES = 4,
    parameter int unsigned LANE_W    = 64,
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned CNT_W     = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic [NUM_LANES*LANE_W-1:0] in_data,
    input  logic [NUM_LANES-1:0]        in_sbe,
    input  logic [NUM_LANES-1:0]        in_dbe,
    input  logic [ADDR_W-1:0]           in_addr,
    output logic                        out_valid,
    output logic [NUM_LANES*LANE_W-1:0] out_data,
    output logic                        out_dbe,
    input  logic                        psel,
    input  logic                        penable,
    input  logic                        pwrite,
    input  logic [7:0]                  paddr,
    input  logic [31:0]                 pwdata,
    output logic [31:0]                 prdata,
    output logic                        pready
);

    localparam int unsigned IDX_W = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1;

    beat_cls_e         cls;
    logic [IDX_W-1:0]  lane_idx;
    logic [CLR_W-1:0]  clr;
    logic [CNT_W-1:0]  sb_cnt;
    logic [CNT_W-1:0]  db_cnt;
    logic              rec_valid;
    logic              rec_dbl;
    logic [IDX_W-1:0]  rec_lane;
    logic [ADDR_W-1:0] rec_addr;

    assign out_valid = in_valid;
    assign out_data  = in_data;
    assign out_dbe   = (cls == BEAT_DOUBLE);

    ecc_lane_fold #(.NUM_LANES(NUM_LANES), .IDX_W(IDX_W)) fold_i (
        .valid    (in_valid),
        .sbe      (in_sbe),
        .dbe      (in_dbe),
        .cls      (cls),
        .lane_idx (lane_idx)
    );

    ecc_sat_counter #(.CNT_W(CNT_W)) sb_cnt_i (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (cls == BEAT_SINGLE),
        .clr   (clr[CLR_SB]),
        .cnt   (sb_cnt)
    );

    ecc_sat_counter #(.CNT_W(CNT_W)) db_cnt_i (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (cls == BEAT_DOUBLE),
        .clr   (clr[CLR_DB]),
        .cnt   (db_cnt)
    );

    ecc_err_log #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) log_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cls       (cls),
        .lane_idx  (lane_idx),
        .addr      (in_addr),
        .clr       (clr[CLR_REC]),
        .rec_valid (rec_valid),
        .rec_dbl   (rec_dbl),
        .rec_lane  (rec_lane),
        .rec_addr  (rec_addr)
    );

    ecc_apb_regs #(.CNT_W(CNT_W), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) regs_i (
        .psel      (psel),
        .penable   (penable),
        .pwrite    (pwrite),
        .paddr     (paddr),
        .pwdata    (pwdata),
        .prdata    (prdata),
        .pready    (pready),
        .sb_cnt    (sb_cnt),
        .db_cnt    (db_cnt),
        .rec_valid (rec_valid),
        .rec_dbl   (rec_dbl),
        .rec_lane  (rec_lane),
        .rec_addr  (rec_addr),
        .clr       (clr)
    );

endmodule

// File: rtl/ecc_beat_classifier_chk.sv
module ecc_beat_classifier_chk #(
    parameter int unsigned NUM_LANES = 4,
    parameter int unsigned CNT_W     = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic [NUM_LANES-1:0] in_dbe,
    input logic                 out_dbe,
    input logic [CNT_W-1:0]     sb_cnt,
    input logic [CNT_W-1:0]     db_cnt,
    input logic [2:0]           clr,
    input logic                 rec_dbl
);

    a_r3_dbe_needs_lane: assert property (@(posedge clk) disable iff (!rst_n)
        out_dbe |-> (in_valid && (|in_dbe)));

    a_r5_sb_frozen_on_dbe: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (|in_dbe)) |=> ($stable(sb_cnt) || sb_cnt == '0));

    a_r6_idle_no_count: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && clr == 3'b000) |=> ($stable(sb_cnt) && $stable(db_cnt)));

    a_r7_sb_step: assert property (@(posedge clk) disable iff (!rst_n)
        (sb_cnt != $past(sb_cnt)) |-> (sb_cnt == $past(sb_cnt) + 1'b1 || sb_cnt == '0));

    a_r7_db_hold_max: assert property (@(posedge clk) disable iff (!rst_n)
        (db_cnt == {CNT_W{1'b1}} && !clr[1]) |=> (db_cnt == {CNT_W{1'b1}}));

    a_r10_double_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_dbl && !clr[2]) |=> rec_dbl);

endmodule

bind ecc_beat_classifier ecc_beat_classifier_chk #(
    .NUM_LANES(NUM_LANES),
    .CNT_W(CNT_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_dbe   (in_dbe),
    .out_dbe  (out_dbe),
    .sb_cnt   (sb_cnt),
    .db_cnt   (db_cnt),
    .clr      (clr),
    .rec_dbl  (rec_dbl)
);

// File: tb/ecc_beat_classifier_tb_top.sv
module ecc_beat_classifier_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NL   = 4;
    localparam int LW   = 64;
    localparam int AW   = 32;
    localparam int CW   = 4;
    localparam int CMAX = 15;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic [NL*LW-1:0] in_data = '0;
    logic [NL-1:0]   in_sbe = '0;
    logic [NL-1:0]   in_dbe = '0;
    logic [AW-1:0]   in_addr = '0;
    logic            out_valid;
    logic [NL*LW-1:0] out_data;
    logic            out_dbe;
    logic            psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0]      paddr = '0;
    logic [31:0]     pwdata = '0;
    logic [31:0]     prdata;
    logic            pready;

    int checks = 0;
    int errors = 0;

    int m_sb = 0, m_db = 0;
    int m_rv = 0, m_rd = 0, m_rl = 0;
    int unsigned m_ra = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ecc_beat_classifier #(.NUM_LANES(NL), .LANE_W(LW), .ADDR_W(AW), .CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_sbe(in_sbe), .in_dbe(in_dbe), .in_addr(in_addr),
        .out_valid(out_valid), .out_data(out_data), .out_dbe(out_dbe),
        .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
        .pwdata(pwdata), .prdata(prdata), .pready(pready)
    );

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int first_lane(input logic [NL-1:0] v);
        for (int i = 0; i < NL; i++) if (v[i]) return i;
        return 0;
    endfunction

    task automatic beat(input logic v, input logic [NL-1:0] s, input logic [NL-1:0] d,
                        input logic [AW-1:0] a);
        logic [NL*LW-1:0] dat;
        @(negedge clk);
        for (int i = 0; i < NL*LW/32; i++) dat[i*32 +: 32] = $urandom;
        in_valid = v; in_sbe = s; in_dbe = d; in_addr = a; in_data = dat;
        #1;
        check("R2 valid", out_valid, v);
        checks++;
        if (out_data !== dat) begin
            errors++;
            $display("FAIL R2 data actual=%0h expected=%0h", out_data, dat);
        end
        check("R3 dbe", out_dbe, (v && d != 0));
        @(posedge clk);
        if (v && d != 0) begin
            if (m_db < CMAX) m_db++;
            m_rv = 1; m_rd = 1; m_rl = first_lane(d); m_ra = a;
        end else if (v && s != 0) begin
            if (m_sb < CMAX) m_sb++;
            if (!(m_rv == 1 && m_rd == 1)) begin
                m_rv = 1; m_rd = 0; m_rl = first_lane(s); m_ra = a;
            end
        end
        #1;
        in_valid = 1'b0; in_sbe = '0; in_dbe = '0;
    endtask

    task automatic apb_read(input logic [7:0] a, input string req, input longint exp);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        #1;
        check(req, prdata, exp);
        check("R11 pready", pready, 1);
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic apb_clear(input logic [2:0] bits);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; paddr = 8'h10; pwdata = 32'(bits); penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        @(posedge clk);
        if (bits[0]) m_sb = 0;
        if (bits[1]) m_db = 0;
        if (bits[2]) begin m_rv = 0; m_rd = 0; m_rl = 0; m_ra = 0; end
        #1;
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic check_all(input string tag);
        apb_read(8'h00, {tag, " sb count (R4)"}, m_sb);
        apb_read(8'h04, {tag, " db count (R5)"}, m_db);
        apb_read(8'h08, {tag, " record (R9)"}, (m_rl << 4) | (m_rd << 1) | m_rv);
        apb_read(8'h0C, {tag, " record addr (R9)"}, m_ra);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        check_all("R1 reset");

        // R4: one and several single-bit lanes
        beat(1, 4'b0100, 4'b0000, 32'h1000);
        check_all("R4 one lane");
        beat(1, 4'b1011, 4'b0000, 32'h1040);
        check_all("R4 multi lane");

        // R6: flags without valid
        beat(0, 4'b1111, 4'b1111, 32'hDEAD);
        check_all("R6 idle flags");

        // R5 and R10: mixed beat outranks, double overwrites single record
        beat(1, 4'b0001, 4'b1100, 32'h2000);
        check_all("R5 mixed");
        beat(1, 4'b0000, 4'b0110, 32'h2040);
        check_all("R5 multi dbe");

        // R10: single must not overwrite held double record
        beat(1, 4'b0001, 4'b0000, 32'h3000);
        check_all("R10 single after double");

        // R8: clear only the record, then single may be captured
        apb_clear(3'b100);
        check_all("R8 clear record");
        beat(1, 4'b1000, 4'b0000, 32'h3040);
        check_all("R10 single after clear");

        // R8: writing zero bits has no effect; clear counters separately
        apb_clear(3'b000);
        check_all("R8 zero write");
        apb_clear(3'b001);
        check_all("R8 clear sb");
        apb_clear(3'b010);
        check_all("R8 clear db");

        // R7: saturation of both counters
        for (int i = 0; i < 20; i++) beat(1, 4'b0010, 4'b0000, 32'h4000 + i);
        for (int i = 0; i < 20; i++) beat(1, 4'b0000, 4'b0001, 32'h5000 + i);
        check_all("R7 saturate");
        beat(0, 4'b0000, 4'b0000, 32'h0);

        // R11: unmapped read returns zero
        apb_read(8'h20, "R11 unmapped", 0);
        apb_read(8'h10, "R11 clear reg read", 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule